// File: doc/BRIEF.md
# Serial Register Control Port

This block is the configuration port of an audio converter. An external controller sends 24-bit frames over four pins: a frame strobe, a serial clock, serial data in and serial data out. Each frame names the device, asks for a read or a write, picks one of seventeen 8-bit configuration registers, and carries one data byte. The register bank lives in the system clock domain and drives the rest of the chip through one flat configuration bus. The serial clock has no phase relation to the system clock.

A write is shifted in on the serial clock and held. It takes effect in the system clock domain only after the strobe goes high, and only if exactly 24 bits arrived. All eight bits of the register change in the same cycle. A read returns the register byte on the data-out pin during the last byte of the same frame. If the three serial input pins are all low when reset is released, the port enters a standalone mode. In that mode it ignores writes and turns on the internal clock-enable bit.

The interface is a plain serial control port, not a data stream, so it has no valid/ready handshake. The strobe, the serial clock and the lock input are plain pins.

Top module: `ctrl_spi_regbank`

## Requirements
- R1: A frame is 24 bits, sent MSB first and sampled on rising serial-clock edges while the strobe is low. Bits 23:17 are the device identifier 0x04, bit 16 is the direction (1 = read, 0 = write), bits 15:8 are the register index and bits 7:0 are the data. A write takes effect when the strobe rises.
- R2: After reset, registers 6 to 13 (the eight channel volume codes) hold 0xFF and every other register holds 0x00. Register 1 bit 3 is the exception and follows `lock_in`.
- R3: After a valid write frame, the addressed byte appears on `cfg_flat[8*i+7:8*i]` within 8 system-clock cycles of the strobe rising.
- R4: A write changes only the addressed register, sets all eight of its bits in a single system-clock cycle, and does so only when a whole frame has completed.
- R5: In a read frame, the addressed register is shifted out MSB first on `spi_dout`. Each bit changes after a falling serial-clock edge, and the controller samples them on rising edges 17 to 24.
- R6: `spi_dout_oe` is high only during the data byte of a read frame that carries the correct identifier and a valid index, and it is low whenever the strobe is high.
- R7: A frame with any identifier other than 0x04 changes no register and never drives `spi_dout_oe`.
- R8: A write to an index above 16 is discarded. Index 14 is reserved: writes to it are ignored and it reads 0x00.
- R9: A frame of fewer or more than 24 bits before the strobe rises changes no register.
- R10: Register 1 bit 3 shows the synchronised `lock_in` level, and written values of that bit have no effect.
- R11: If the strobe, the serial clock and the serial data in are all low when reset is released, register 0 bit 7 becomes 1, all other registers keep their reset values, and serial writes are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_latch | input | 1 | Frame strobe, low for the duration of a frame |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_din | input | 1 | Serial data into the block |
| spi_dout | output | 1 | Serial read data |
| spi_dout_oe | output | 1 | Drive enable for `spi_dout` (low means high impedance) |
| lock_in | input | 1 | Clock-lock status from the clock generator |
| cfg_flat | output | 136 | Seventeen registers, register i in bits 8*i+7:8*i |

## Verification
Most wrong internal state shows up on `cfg_flat` within a few system cycles after the strobe rises. A miscounted bit, a wrong identifier compare or a missed overrun produces a changed byte that should have stayed put, or an unchanged byte that should have changed. Errors in the read path show up in the same frame: the enable is asserted at the wrong bit positions, or the byte on `spi_dout` is shifted by one or taken from the wrong register. A stale pending write is only visible one frame later, when a later strobe commits it, so each rejection test is followed by a readback or a state comparison.

// File: rtl/ctrl_spi_pkg.sv
`timescale 1ns/1ps
package ctrl_spi_pkg;
  localparam int unsigned FRAME_BITS = 24;
  localparam int unsigned NREG       = 17;
  localparam logic [6:0]  DEV_ID     = 7'h04;
  localparam int unsigned RSVD_IDX   = 14;
  localparam int unsigned VOL_LO     = 6;
  localparam int unsigned VOL_HI     = 13;
  localparam int unsigned STAT_IDX   = 1;
  localparam int unsigned STAT_BIT   = 3;
  localparam int unsigned CKEN_IDX   = 0;
  localparam int unsigned CKEN_BIT   = 7;
  localparam logic [7:0]  VOL_FULL   = 8'hFF;

  typedef struct packed {
    logic [6:0] dev;
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;
  } ctl_frame_t;
endpackage

// File: rtl/ctrl_spi_shifter.sv
`timescale 1ns/1ps
// Serial-clock domain: bit counter, input shifter, read serializer.
module ctrl_spi_shifter
  import ctrl_spi_pkg::*;
(
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_latch,
  input  logic       spi_din,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output ctl_frame_t frame_hold,
  output logic       frame_tgl,
  output logic       over_tgl,
  output logic       spi_dout,
  output logic       spi_dout_oe
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] C_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(FRAME_BITS - 8);

  logic                  clr;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sh;
  logic [7:0]            rsh;
  logic                  rd_hit;

  // Strobe high (or reset) holds the frame state cleared.
  assign clr = spi_latch | ~rst_n;

  always_ff @(posedge spi_sclk or posedge clr) begin
    if (clr) begin
      cnt <= '0;
      sh  <= '0;
    end else begin
      if (cnt != C_SAT)  cnt <= cnt + 1'b1;
      if (cnt < C_FULL)  sh  <= {sh[FRAME_BITS-2:0], spi_din};
    end
  end

  // Completed frame held for the system domain; toggles flag events.
  always_ff @(posedge spi_sclk or negedge rst_n) begin
    if (!rst_n) begin
      frame_hold <= '0;
      frame_tgl  <= 1'b0;
      over_tgl   <= 1'b0;
    end else if (cnt == C_LAST) begin
      frame_hold <= {sh[FRAME_BITS-2:0], spi_din};
      frame_tgl  <= ~frame_tgl;
    end else if (cnt == C_FULL) begin
      over_tgl   <= ~over_tgl;
    end
  end

  assign rd_addr = sh[7:0];
  assign rd_hit  = (cnt == C_HDR) && (sh[15:9] == DEV_ID) && sh[8] &&
                   (sh[7:0] < 8'(NREG));

  always_ff @(negedge spi_sclk or posedge clr) begin
    if (clr) begin
      spi_dout_oe <= 1'b0;
      rsh         <= '0;
    end else if (rd_hit) begin
      spi_dout_oe <= 1'b1;
      rsh         <= rd_data;
    end else if (spi_dout_oe) begin
      if (cnt == C_FULL) spi_dout_oe <= 1'b0;
      else               rsh <= {rsh[6:0], 1'b0};
    end
  end

  assign spi_dout = rsh[7];
endmodule

// File: rtl/ctrl_spi_commit.sv
`timescale 1ns/1ps
// System domain: synchronise strobe and toggles, commit a write on strobe rise.
module ctrl_spi_commit
  import ctrl_spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_latch,
  input  logic       frame_tgl,
  input  logic       over_tgl,
  input  ctl_frame_t frame_hold,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  logic [2:0] s1, s2, s3;
  logic       latch_rise, frame_ev, over_ev, pending, legal;
  ctl_frame_t frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 3'b001;
      s2 <= 3'b001;
      s3 <= 3'b001;
    end else begin
      s1 <= {over_tgl, frame_tgl, spi_latch};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign latch_rise = s2[0] & ~s3[0];
  assign frame_ev   = s2[1] ^ s3[1];
  assign over_ev    = s2[2] ^ s3[2];
  assign legal      = (frame_q.dev == DEV_ID) && !frame_q.rd &&
                      (frame_q.addr < 8'(NREG)) && (frame_q.addr != 8'(RSVD_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      frame_q <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (latch_rise) begin
        pending <= 1'b0;
        wr_en   <= pending && !over_ev && !frame_ev && legal;
        wr_addr <= frame_q.addr;
        wr_data <= frame_q.data;
      end else if (over_ev) begin
        pending <= 1'b0;
      end else if (frame_ev) begin
        pending <= 1'b1;
        frame_q <= frame_hold;
      end
    end
  end
endmodule

// File: rtl/ctrl_spi_bank.sv
`timescale 1ns/1ps
// System domain register bank with standalone detection and lock status.
module ctrl_spi_bank
  import ctrl_spi_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      pin_latch,
  input  logic                      pin_sclk,
  input  logic                      pin_din,
  input  logic                      lock_in,
  output logic                      sa_pulse,
  output logic [NREG-1:0][7:0]      cfg
);
  logic [2:0]            pin_s1, pin_s2;
  logic [1:0]            init_cnt;
  logic                  standalone;
  logic [1:0]            lock_s;
  logic [NREG-1:0][7:0]  store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1     <= 3'b111;
      pin_s2     <= 3'b111;
      init_cnt   <= '0;
      standalone <= 1'b0;
      lock_s     <= '0;
    end else begin
      pin_s1 <= {pin_latch, pin_sclk, pin_din};
      pin_s2 <= pin_s1;
      lock_s <= {lock_s[0], lock_in};
      if (init_cnt != 2'd3) init_cnt <= init_cnt + 1'b1;
      if (sa_pulse) standalone <= 1'b1;
    end
  end

  // Pins are valid in pin_s2 two cycles after reset release.
  assign sa_pulse = (init_cnt == 2'd2) && (pin_s2 == 3'b000);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RV = (g >= VOL_LO && g <= VOL_HI) ? VOL_FULL : 8'h00;
    localparam logic [7:0] WM = (g == RSVD_IDX) ? 8'h00 :
                                (g == STAT_IDX) ? ~(8'h01 << STAT_BIT) : 8'hFF;
    localparam logic [7:0] SA = (g == CKEN_IDX) ? (8'h01 << CKEN_BIT) : 8'h00;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store[g] <= RV;
      else if (sa_pulse)
        store[g] <= store[g] | SA;
      else if (wr_en && !standalone && wr_addr == 8'(g))
        store[g] <= wr_data & WM;
    end
  end

  always_comb begin
    cfg = store;
    cfg[STAT_IDX][STAT_BIT] = lock_s[1];
  end
endmodule

// File: rtl/ctrl_spi_regbank.sv
`timescale 1ns/1ps
module ctrl_spi_regbank
  import ctrl_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_latch,
  input  logic               spi_sclk,
  input  logic               spi_din,
  output logic               spi_dout,
  output logic               spi_dout_oe,
  input  logic               lock_in,
  output logic [NREG*8-1:0]  cfg_flat
);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic [7:0]           rd_addr, rd_data, wr_addr, wr_data;
  ctl_frame_t           frame_hold;
  logic                 frame_tgl, over_tgl, wr_en, sa_pulse;
  logic [NREG-1:0][7:0] cfg;

  ctrl_spi_shifter u_shift (
    .rst_n, .spi_sclk, .spi_latch, .spi_din,
    .rd_data, .rd_addr, .frame_hold, .frame_tgl, .over_tgl,
    .spi_dout, .spi_dout_oe
  );

  ctrl_spi_commit u_commit (
    .clk, .rst_n, .spi_latch, .frame_tgl, .over_tgl, .frame_hold,
    .wr_en, .wr_addr, .wr_data
  );

  ctrl_spi_bank u_bank (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .pin_latch(spi_latch), .pin_sclk(spi_sclk), .pin_din(spi_din),
    .lock_in, .sa_pulse, .cfg
  );

  // Configuration is quasi-static while a read frame is in flight.
  assign rd_data  = (rd_addr < 8'(NREG)) ? cfg[rd_addr[IDX_W-1:0]] : 8'h00;
  assign cfg_flat = cfg;
endmodule

// File: rtl/ctrl_spi_checker.sv
`timescale 1ns/1ps
module ctrl_spi_checker
  import ctrl_spi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              spi_latch,
  input logic              spi_dout_oe,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic              sa_pulse,
  input logic [NREG*8-1:0] cfg_flat
);
  logic [NREG*8-1:0] cfg_m;
  always_comb begin
    cfg_m = cfg_flat;
    cfg_m[STAT_IDX*8 + STAT_BIT] = 1'b0;
  end

  assert_oe_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_dout_oe |-> !spi_latch);

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_wr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < 8'(NREG)) && (wr_addr != 8'(RSVD_IDX)));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flat[RSVD_IDX*8 +: 8] == 8'h00);

  assert_atomic_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_m != $past(cfg_m)) |-> ($past(wr_en) || $past(sa_pulse)));
endmodule

bind ctrl_spi_regbank ctrl_spi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_latch(spi_latch), .spi_dout_oe(spi_dout_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .sa_pulse(sa_pulse), .cfg_flat(cfg_flat)
);

// File: tb/tb_ctrl_spi_regbank.sv
`timescale 1ns/1ps
module tb_ctrl_spi_regbank;
  localparam int NR = 17;
  localparam int W  = NR * 8;
  localparam time HALF = 100ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_latch = 1'b1, spi_sclk = 1'b0, spi_din = 1'b0, lock_in = 1'b0;
  logic spi_dout, spi_dout_oe;
  logic [W-1:0] cfg_flat;
  int n_tests = 0, n_fail = 0;

  always #10ns clk = ~clk;

  ctrl_spi_regbank dut (
    .clk, .rst_n, .spi_latch, .spi_sclk, .spi_din,
    .spi_dout, .spi_dout_oe, .lock_in, .cfg_flat
  );

  function automatic logic [23:0] mk(input logic [6:0] dev, input logic rw,
                                     input logic [7:0] a, input logic [7:0] d);
    return {dev, rw, a, d};
  endfunction

  function automatic logic [7:0] rg(input int a);
    return cfg_flat[a*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic sa);
    spi_latch = sa ? 1'b0 : 1'b1;
    spi_sclk = 1'b0; spi_din = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    spi_latch = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Sends n bits of vec MSB first; collects bits 17..24 and counts enable mismatches.
  task automatic frame(input logic [31:0] vec, input int n, input logic exp_rd,
                       output logic [7:0] rd, output int oe_bad);
    rd = '0; oe_bad = 0;
    spi_latch = 1'b0;
    #(HALF);
    for (int i = 0; i < n; i++) begin
      spi_din = vec[n-1-i];
      #(HALF);
      if ((i + 1) >= 17 && (i + 1) <= 24) rd = {rd[6:0], spi_dout};
      if (spi_dout_oe !== (exp_rd && (i + 1) >= 17 && (i + 1) <= 24)) oe_bad++;
      spi_sclk = 1'b1;
      #(HALF);
      spi_sclk = 1'b0;
    end
    #(HALF);
    spi_latch = 1'b1;
    #(HALF);
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r; int b;
    frame({8'h0, mk(7'h04, 1'b0, a, d)}, 24, 1'b0, r, b);
  endtask

  task automatic t_reset;
    for (int a = 0; a < NR; a++)
      chk($sformatf("R2 reset reg%0d", a), W'(rg(a)),
          W'((a >= 6 && a <= 13) ? 8'hFF : 8'h00));
    chk("R6 oe idle after reset", W'(spi_dout_oe), W'(0));
  endtask

  task automatic t_write;
    logic [W-1:0] snap;
    wr(8'd0, 8'h80);
    chk("R3 R1 write reg0", W'(rg(0)), W'(8'h80));
    snap = cfg_flat;
    wr(8'd9, 8'h3C);
    snap[9*8 +: 8] = 8'h3C;
    chk("R4 only reg9 changes", cfg_flat, snap);
    wr(8'd16, 8'hA5);
    chk("R3 write reg16", W'(rg(16)), W'(8'hA5));
  endtask

  task automatic t_read;
    logic [7:0] r; int b;
    frame({8'h0, mk(7'h04, 1'b1, 8'd9, 8'h00)}, 24, 1'b1, r, b);
    chk("R5 read reg9", W'(r), W'(8'h3C));
    chk("R6 oe window on read", W'(b), W'(0));
    chk("R5 read does not modify", W'(rg(9)), W'(8'h3C));
    frame({8'h0, mk(7'h04, 1'b1, 8'd13, 8'h00)}, 24, 1'b1, r, b);
    chk("R5 read reg13", W'(r), W'(8'hFF));
    frame({8'h0, mk(7'h04, 1'b0, 8'd7, 8'h42)}, 24, 1'b0, r, b);
    chk("R6 oe low in write frame", W'(b), W'(0));
    chk("R3 write reg7", W'(rg(7)), W'(8'h42));
  endtask

  task automatic t_bad_dev;
    logic [7:0] r; int b; logic [W-1:0] snap;
    snap = cfg_flat;
    frame({8'h0, mk(7'h05, 1'b0, 8'd9, 8'h11)}, 24, 1'b0, r, b);
    chk("R7 wrong id write dropped", cfg_flat, snap);
    frame({8'h0, mk(7'h02, 1'b1, 8'd9, 8'h00)}, 24, 1'b0, r, b);
    chk("R7 wrong id read never drives", W'(b), W'(0));
  endtask

  task automatic t_bad_addr;
    logic [7:0] r; int b; logic [W-1:0] snap;
    snap = cfg_flat;
    wr(8'd17, 8'h77);
    chk("R8 index 17 dropped", cfg_flat, snap);
    wr(8'd200, 8'h77);
    chk("R8 index 200 dropped", cfg_flat, snap);
    wr(8'd14, 8'h55);
    chk("R8 reserved write ignored", cfg_flat, snap);
    frame({8'h0, mk(7'h04, 1'b1, 8'd14, 8'h00)}, 24, 1'b1, r, b);
    chk("R8 reserved reads zero", W'(r), W'(8'h00));
  endtask

  task automatic t_length;
    logic [7:0] r; int b; logic [W-1:0] snap;
    logic [23:0] f;
    snap = cfg_flat;
    f = mk(7'h04, 1'b0, 8'd10, 8'h5A);
    frame({9'h0, f[23:1]}, 23, 1'b0, r, b);
    chk("R9 23-bit frame dropped", cfg_flat, snap);
    frame({7'h0, f, 1'b1}, 25, 1'b0, r, b);
    chk("R9 25-bit frame dropped", cfg_flat, snap);
    frame({8'h0, f}, 24, 1'b0, r, b);
    chk("R9 24-bit frame applied", W'(rg(10)), W'(8'h5A));
  endtask

  task automatic t_lock;
    logic [7:0] r; int b;
    lock_in = 1'b0;
    wr(8'd1, 8'hFF);
    chk("R10 lock bit not writable", W'(rg(1)), W'(8'hF7));
    lock_in = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'd1, 8'h00);
    chk("R10 lock bit follows input", W'(rg(1)), W'(8'h08));
    frame({8'h0, mk(7'h04, 1'b1, 8'd1, 8'h00)}, 24, 1'b1, r, b);
    chk("R10 lock bit read back", W'(r), W'(8'h08));
    lock_in = 1'b0;
  endtask

  task automatic t_standalone;
    logic [W-1:0] exp;
    do_reset(1'b1);
    exp = '0;
    for (int a = 6; a <= 13; a++) exp[a*8 +: 8] = 8'hFF;
    exp[7] = 1'b1;
    chk("R11 standalone defaults", cfg_flat, exp);
    wr(8'd9, 8'h01);
    chk("R11 standalone ignores writes", cfg_flat, exp);
  endtask

  initial begin
    #(20ns * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_reset();
    t_write();
    t_read();
    t_bad_dev();
    t_bad_addr();
    t_length();
    t_lock();
    t_standalone();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule